// File: doc/BRIEF.md
# Dual Alarm Match Interrupt Unit

This unit holds two sets of alarm registers and compares each set against the running calendar time whenever the once-per-second update strobe arrives. Each alarm byte carries its own match-enable bit, so a field whose enable is clear is treated as a wildcard. This allows alarms such as "every minute at second 30" or "every Monday at 07:00". When every enabled field of a set equals the current time, that set's alarm flag is raised. If the set's interrupt enable is on, a single active-low pulse of fixed length is also emitted on the shared interrupt line.

A mode input selects between one-shot and recurring behaviour. In one-shot mode an alarm fires once and then stays quiet until software writes any register of that set. In recurring mode it fires on every matching update. The flags stay raised until a neighbouring serial-interface block signals that a read of the status byte has completed. This unit supplies that byte's alarm bits on a dedicated output.

All pins are plain control and status signals. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure. A register write is accepted in the cycle its strobe is high.

Top module: `alarm_irq_unit`

## Requirements
- R1: On a cycle with `tick` high, an alarm matches only when every one of its fields with bit 7 set equals the current time under that field's mask: seconds 0x7F, minutes 0x7F, hours 0x3F, date 0x3F, month 0x1F, day-of-week 0x07. Fields with bit 7 clear are ignored in the comparison.
- R2: An alarm with no enable bit set in any of its six fields never matches.
- R3: A matching alarm raises its flag even when its interrupt enable is 0. In that case `irq_n` stays high.
- R4: A `status_rd_done` pulse clears both flags at the next edge. If an alarm fires in the same cycle, that alarm's flag is set instead of cleared.
- R5: When an alarm fires and its `irq_en` bit is 1, `irq_n` goes low at the following clock edge and stays low for exactly CLK_HZ*PULSE_MS/1000 cycles. The line is shared by both alarms.
- R6: With `repeat_mode` at 0, an alarm fires at most once until any of its registers is written again. With `repeat_mode` at 1, it fires on every matching tick.
- R7: Matching is evaluated only on cycles with `tick` high. A matching time presented without `tick` sets no flag and produces no pulse.
- R8: `flag_byte` carries alarm 1's flag in bit 6 and alarm 0's flag in bit 5. All other bits of `flag_byte` are 0.
- R9: After reset, both flags are 0, `irq_n` is 1, and every alarm register is 0x00 (no field enabled).
- R10: Register writes use `wr_addr[3]` to select the alarm (0 or 1). `wr_addr[2:0]` selects the field: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day-of-week. Slots 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Once-per-second time update strobe |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current date, BCD |
| cur_month | input | 8 | Current month, BCD |
| cur_dow | input | 8 | Current day of week, 0-6 |
| wr_en | input | 1 | Alarm register write strobe |
| wr_addr | input | 4 | Alarm select (bit 3) and field slot (bits 2:0) |
| wr_data | input | 8 | Alarm byte: bit 7 enable, bits 6:0 BCD value |
| irq_en | input | 2 | Per-alarm interrupt enable (bit i for alarm i) |
| repeat_mode | input | 1 | 0 one-shot, 1 recurring |
| status_rd_done | input | 1 | Status byte read completed |
| alarm_flag | output | 2 | Alarm flags (bit i for alarm i) |
| flag_byte | output | 8 | Status-byte view of the flags |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
The bench builds the unit with CLK_HZ=200 and PULSE_MS=20. This gives a pulse of 4 cycles, so the exact low width and the return to high fit inside a short window after each firing. With the default values the pulse would last hundreds of cycles, and the width check would dominate the run time. The short pulse also lets the bench place a second tick right after a pulse. This makes the one-shot re-arm sequence and the coincident read-and-fire case cheap to reach.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NUM_ALARMS = 2;
  localparam int NUM_FIELDS = 6;
  localparam int SLOT_W     = 3;
  localparam int ADDR_W     = SLOT_W + 1;

  typedef logic [7:0] abyte_t;

  // value bits that take part in the comparison for each field slot
  function automatic abyte_t field_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      4:       return 8'h1F;
      default: return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_irq_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  abyte_t                       wr_data,
  output abyte_t [NUM_ALARMS-1:0][NUM_FIELDS-1:0] regs,
  output logic [NUM_ALARMS-1:0]        rewritten
);
  logic [SLOT_W-1:0] slot;
  logic              sel;

  assign slot = wr_addr[SLOT_W-1:0];
  assign sel  = wr_addr[ADDR_W-1];

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_set
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[a][f] <= '0;
        else if (wr_en && (int'(sel) == a) && (int'(slot) == f))
          regs[a][f] <= wr_data;
      end
    end
    assign rewritten[a] = wr_en && (int'(sel) == a) && (int'(slot) < NUM_FIELDS);
  end
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
  import alarm_irq_pkg::*;
(
  input  abyte_t [NUM_FIELDS-1:0] alarm_regs,
  input  abyte_t [NUM_FIELDS-1:0] now,
  output logic                    hit
);
  logic [NUM_FIELDS-1:0] fld_ok;
  logic [NUM_FIELDS-1:0] fld_en;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
    assign fld_en[f] = alarm_regs[f][7];
    assign fld_ok[f] = !fld_en[f] ||
                       (((alarm_regs[f] ^ now[f]) & field_mask(f)) == 8'h00);
  end

  assign hit = (|fld_en) && (&fld_ok);
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int PULSE_CYCLES = 655
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic irq_n
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain <= '0;
    else if (trigger)
      remain <= CW'(PULSE_CYCLES);
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign irq_n = (remain == '0);

  // the line may only drop right after a trigger
  assert_drop_needs_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(trigger));
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
#(
  parameter int CLK_HZ   = 32768,
  parameter int PULSE_MS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_date,
  input  logic [7:0]        cur_month,
  input  logic [7:0]        cur_dow,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        irq_en,
  input  logic              repeat_mode,
  input  logic              status_rd_done,
  output logic [1:0]        alarm_flag,
  output logic [7:0]        flag_byte,
  output logic              irq_n
);
  localparam int PULSE_CYCLES = (CLK_HZ * PULSE_MS) / 1000;

  abyte_t [NUM_ALARMS-1:0][NUM_FIELDS-1:0] regs;
  abyte_t [NUM_FIELDS-1:0]                 now;
  logic   [NUM_ALARMS-1:0]                 rewritten, hit, fire, armed;

  assign now = {cur_dow, cur_month, cur_date, cur_hour, cur_min, cur_sec};

  alarm_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .regs      (regs),
    .rewritten (rewritten)
  );

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    alarm_matcher u_match (
      .alarm_regs (regs[a]),
      .now        (now),
      .hit        (hit[a])
    );

    assign fire[a] = tick && hit[a] && (repeat_mode || armed[a]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        armed[a] <= 1'b1;
      else if (rewritten[a])
        armed[a] <= 1'b1;
      else if (fire[a] && !repeat_mode)
        armed[a] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        alarm_flag[a] <= 1'b0;
      else if (fire[a])
        alarm_flag[a] <= 1'b1;
      else if (status_rd_done)
        alarm_flag[a] <= 1'b0;
    end

    // an alarm without any field enable can never report a hit
    assert_no_enable_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[a][0][7] == 1'b0 && regs[a][1][7] == 1'b0 && regs[a][2][7] == 1'b0 &&
       regs[a][3][7] == 1'b0 && regs[a][4][7] == 1'b0 && regs[a][5][7] == 1'b0)
      |-> !hit[a]);

    assert_flag_rise_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag[a]) |-> $past(tick));

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd_done && !tick) |=> !alarm_flag[a]);
  end

  irq_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (|(fire & irq_en)),
    .irq_n   (irq_n)
  );

  assign flag_byte = {1'b0, alarm_flag[1], alarm_flag[0], 5'b00000};

  assert_pulse_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(tick && (irq_en != 2'b00)));
endmodule

// File: tb/alarm_irq_unit_test.sv
module alarm_irq_unit_test;
  localparam int PULSE = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_date = 0, cur_month = 0, cur_dow = 0;
  logic wr_en = 0; logic [3:0] wr_addr = 0; logic [7:0] wr_data = 0;
  logic [1:0] irq_en = 0; logic repeat_mode = 0, status_rd_done = 0;
  logic [1:0] alarm_flag; logic [7:0] flag_byte; logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alarm_irq_unit #(.CLK_HZ(200), .PULSE_MS(20)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_date(cur_date), .cur_month(cur_month), .cur_dow(cur_dow),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_en(irq_en),
    .repeat_mode(repeat_mode), .status_rd_done(status_rd_done),
    .alarm_flag(alarm_flag), .flag_byte(flag_byte), .irq_n(irq_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 16; i++) wr(4'(i), 8'h00);
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, w);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; cur_month = mo; cur_dow = w;
  endtask

  // one tick; on return it is the negedge right after the sampling edge
  task automatic do_tick(input bit with_read = 0);
    @(negedge clk); tick = 1; status_rd_done = with_read;
    @(negedge clk); tick = 0; status_rd_done = 0;
  endtask

  task automatic status_read();
    @(negedge clk); status_rd_done = 1;
    @(negedge clk); status_rd_done = 0;
  endtask

  // counts low cycles starting at the current negedge
  task automatic count_low(output int n);
    n = 0;
    for (int i = 0; i < 20 && irq_n == 1'b0; i++) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check(alarm_flag == 2'b00, "R9 flags", alarm_flag, 0);
    check(irq_n == 1'b1, "R9 irq_n", irq_n, 1);
    check(flag_byte == 8'h00, "R9 flag_byte", flag_byte, 0);
  endtask

  task automatic t_no_enable();
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00); irq_en = 2'b11;
    do_tick();
    check(alarm_flag == 2'b00, "R2 zero regs never match", alarm_flag, 0);
    check(irq_n == 1'b1, "R2 no pulse", irq_n, 1);
  endtask

  task automatic t_single_field();
    int n;
    clear_all(); irq_en = 2'b01; repeat_mode = 1;
    wr(4'h0, 8'hB0);                       // alarm0 seconds == 30 enabled
    set_time(8'h30, 8'h42, 8'h11, 8'h05, 8'h03, 8'h02);
    do_tick();
    check(alarm_flag == 2'b01, "R1 seconds wildcard match", alarm_flag, 1);
    count_low(n);
    check(n == PULSE, "R5 pulse width", n, PULSE);
    check(irq_n == 1'b1, "R5 line returns high", irq_n, 1);
    check(flag_byte == 8'h20, "R8 alarm0 at bit 5", flag_byte, 8'h20);
    status_read();
    check(alarm_flag == 2'b00, "R4 read clears", alarm_flag, 0);
    set_time(8'h31, 8'h42, 8'h11, 8'h05, 8'h03, 8'h02);
    do_tick();
    check(alarm_flag == 2'b00, "R1 seconds mismatch", alarm_flag, 0);
  endtask

  task automatic t_multi_field();
    int n;
    clear_all(); irq_en = 2'b10; repeat_mode = 1;
    wr(4'h9, 8'h95);                       // alarm1 minutes 15
    wr(4'hA, 8'h87);                       // alarm1 hours 07
    wr(4'hD, 8'h81);                       // alarm1 day-of-week 1
    set_time(8'h59, 8'h15, 8'h07, 8'h21, 8'h12, 8'h01);
    do_tick();
    check(alarm_flag == 2'b10, "R1 three fields match", alarm_flag, 2);
    check(flag_byte == 8'h40, "R8 alarm1 at bit 6", flag_byte, 8'h40);
    count_low(n);
    check(n == PULSE, "R5 alarm1 pulse width", n, PULSE);
    status_read();
    set_time(8'h59, 8'h15, 8'h08, 8'h21, 8'h12, 8'h01);
    do_tick();
    check(alarm_flag == 2'b00, "R1 hour differs", alarm_flag, 0);
    set_time(8'h59, 8'h15, 8'h07, 8'h21, 8'h12, 8'h03);
    do_tick();
    check(alarm_flag == 2'b00, "R1 day-of-week differs", alarm_flag, 0);
  endtask

  task automatic t_no_irq_enable();
    clear_all(); irq_en = 2'b00; repeat_mode = 1;
    wr(4'h1, 8'hA5);                       // alarm0 minutes 25
    set_time(8'h00, 8'h25, 8'h00, 8'h01, 8'h01, 8'h00);
    do_tick();
    check(alarm_flag == 2'b01, "R3 flag without irq enable", alarm_flag, 1);
    check(irq_n == 1'b1, "R3 irq_n stays high", irq_n, 1);
    status_read();
  endtask

  task automatic t_read_collision();
    irq_en = 2'b01; repeat_mode = 1;       // alarm0 minutes 25 still set
    do_tick(1);
    check(alarm_flag == 2'b01, "R4 fire beats read", alarm_flag, 1);
    repeat (PULSE + 1) @(negedge clk);
    status_read();
    check(alarm_flag == 2'b00, "R4 later read clears", alarm_flag, 0);
  endtask

  task automatic t_no_tick();
    @(negedge clk); @(negedge clk);        // matching time held, no tick
    check(alarm_flag == 2'b00, "R7 no flag without tick", alarm_flag, 0);
    check(irq_n == 1'b1, "R7 no pulse without tick", irq_n, 1);
  endtask

  task automatic t_one_shot();
    int n;
    clear_all(); irq_en = 2'b01; repeat_mode = 0;
    wr(4'h3, 8'h94);                       // alarm0 date 14
    set_time(8'h00, 8'h00, 8'h00, 8'h14, 8'h06, 8'h04);
    do_tick();
    check(alarm_flag == 2'b01, "R6 one-shot first fire", alarm_flag, 1);
    repeat (PULSE + 1) @(negedge clk);
    status_read();
    do_tick();
    check(alarm_flag == 2'b00, "R6 one-shot second match silent", alarm_flag, 0);
    check(irq_n == 1'b1, "R6 one-shot no second pulse", irq_n, 1);
    wr(4'h3, 8'h94);                       // rewrite re-arms
    do_tick();
    check(alarm_flag == 2'b01, "R6 rewrite rearms", alarm_flag, 1);
    repeat (PULSE + 1) @(negedge clk);
    status_read();
    wr(4'h6, 8'hFF);                       // slot 6 ignored: not a rewrite (R10)
    do_tick();
    check(alarm_flag == 2'b00, "R10 slot 6 write ignored", alarm_flag, 0);
    repeat_mode = 1;
    do_tick();
    check(alarm_flag == 2'b01, "R6 repeat fires", alarm_flag, 1);
    count_low(n);
    status_read();
    do_tick();
    check(alarm_flag == 2'b01, "R6 repeat fires again", alarm_flag, 1);
    count_low(n);
    check(n == PULSE, "R6 repeat pulse", n, PULSE);
    status_read();
  endtask

  task automatic t_month_mask();
    clear_all(); irq_en = 2'b00; repeat_mode = 1;
    wr(4'hC, 8'h92);                       // alarm1 month 12; bits above mask differ
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'hF2, 8'h00);
    do_tick();
    check(alarm_flag == 2'b10, "R1 month mask 0x1F", alarm_flag, 2);
    status_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_enable();
    t_single_field();
    t_multi_field();
    t_no_irq_enable();
    t_read_collision();
    t_no_tick();
    t_one_shot();
    t_month_mask();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule